// File: doc/BRIEF.md
# Dual-Identity Two-Wire Slave Front End

This block is the bus-facing half of a two-wire (I2C) slave that presents two logical targets behind one pair of pins. It oversamples SCL and SDA on the system clock and finds START and STOP conditions. It then collects the first byte of each transaction and decides from its upper nibble which target is meant. Nibble 1010b reaches a large byte memory. Nibble 1101b reaches a small register bank. A 2-bit select field, compared against two strap inputs, lets up to four such parts share one bus.

The memory target takes a two-byte address and keeps a free-running byte pointer that survives between transactions. The register target takes a one-byte address and rejects any value above the last register with a NACK, which ends the transaction. Both targets auto-increment their pointer after every byte in either direction. Each back end sees a plain pointer, a write strobe with write data, and combinational read data.

SDA is driven through an active-low output enable that only ever pulls the line low. Every change of that enable takes place while SCL is low.

Top module: `dual_i2c_slave`

## Requirements
- R1: The first byte after a START is decoded as follows. Bits 7:4 = 1010b select the memory and 1101b select the register bank. Bits 2:1 must equal `sel_i`. Bit 3 is ignored. Bit 0 = 1 means read and 0 means write. The slave acknowledges only on a full match. Otherwise it never pulls SDA low and ignores the bus until the next START.
- R2: After each byte it accepts, the slave holds `sda_oe_no` low (driving SDA to 0) for the whole high phase of the ninth SCL pulse.
- R3: A memory write sends the address high byte first and then the low byte. The pointer becomes the low MEM_AW bits of {high, low}. Each later byte is written at the pointer, and the pointer then increments, wrapping from 2^MEM_AW-1 to 0.
- R4: A read returns the byte at the current pointer, MSB first, and the pointer increments after each byte sent. A master ACK (SDA 0 in the ninth bit) starts the next byte. A master NACK releases SDA and ends the read.
- R5: A register address byte from 00h to REG_LAST (default 18h) is acknowledged and loaded into the pointer. A larger value is NACKed, and every following byte up to the next START is also left unacknowledged, with no register write.
- R6: The register pointer increments after each byte written or read, wrapping from REG_LAST to 00h. `reg_addr_o` never exceeds REG_LAST.
- R7: A register transaction never writes memory or moves `mem_addr_o`. A memory transaction never writes a register.
- R8: A START, including a repeated START in the middle of a byte, returns the slave to the address byte, and an unfinished byte is discarded. After a STOP, bytes sent without a START are ignored.
- R9: `sda_oe_no` changes only while SCL is low, and it is high (released) out of reset.
- R10: Each accepted data byte produces exactly one single-cycle write strobe. `mem_we_o` and `reg_we_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_no | output | 1 | 0 pulls SDA low, 1 releases it |
| sel_i | input | 2 | Strap value matched against address bits 2:1 |
| mem_addr_o | output | MEM_AW | Memory byte pointer |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe, one cycle |
| mem_rdata_i | input | 8 | Memory byte at `mem_addr_o` |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_rdata_i | input | 8 | Register at `reg_addr_o` |

## Verification
The hardest states to reach from the pins are a repeated START that arrives partway through a data byte and the aborted state left behind by an out-of-range register address. The bench reaches the first by sending four data bits and then a new START that selects the other target. It reaches the second by sending address FFh followed by more data, and then checks that neither byte is acknowledged and that no strobe fires. Pointer wrap is reached by starting writes and reads a few bytes before the last memory and register address. Address decode is swept over all 256 first-byte values and all select straps.

// File: rtl/dual_i2c_pkg.sv
package dual_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKSET, ST_SACK, ST_TX, ST_MACK, ST_MNEXT
  } st_e;

  typedef enum logic [2:0] {
    RL_ADDR, RL_AHI, RL_ALO, RL_RADDR, RL_DATA
  } role_e;

  localparam logic [3:0] ID_MEM = 4'b1010;
  localparam logic [3:0] ID_REG = 4'b1101;
  localparam int         LDW    = 16;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // [STAGES-1] is the synchronised value, [STAGES] the one before it
  logic [STAGES:0] scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_p[STAGES-1];
  assign scl_old = scl_p[STAGES];
  assign sda_now = sda_p[STAGES-1];
  assign sda_old = sda_p[STAGES];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] LAST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (ld_i)  ptr_o <= ld_val_i;
    else if (inc_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import dual_i2c_pkg::*;
#(
  parameter logic [7:0] REG_LAST = 8'h18
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sda_i,
  input  logic           scl_rise_i,
  input  logic           scl_fall_i,
  input  logic           start_i,
  input  logic           stop_i,
  input  logic [1:0]     sel_i,
  input  logic [7:0]     mem_rdata_i,
  input  logic [7:0]     reg_rdata_i,
  output logic           drive_o,
  output logic [7:0]     wdata_o,
  output logic           mem_we_o,
  output logic           reg_we_o,
  output logic           mem_rinc_o,
  output logic           reg_rinc_o,
  output logic           mem_ld_o,
  output logic           reg_ld_o,
  output logic [LDW-1:0] ld_val_o
);
  st_e        state;
  role_e      role;
  logic       is_reg, is_rd, ack_q;
  logic [2:0] cnt;
  logic [7:0] sh, hi_q;
  logic [7:0] rx_byte, rd_byte;
  logic       id_ok;

  assign rx_byte = {sh[6:0], sda_i};
  assign rd_byte = is_reg ? reg_rdata_i : mem_rdata_i;
  assign id_ok   = (rx_byte[2:1] == sel_i) &&
                   (rx_byte[7:4] == ID_MEM || rx_byte[7:4] == ID_REG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;  role <= RL_ADDR;
      is_reg <= 1'b0;    is_rd <= 1'b0;   ack_q <= 1'b0;
      cnt <= '0;         sh <= '0;        hi_q <= '0;
      drive_o <= 1'b0;   wdata_o <= '0;   ld_val_o <= '0;
      mem_we_o <= 1'b0;  reg_we_o <= 1'b0;
      mem_rinc_o <= 1'b0; reg_rinc_o <= 1'b0;
      mem_ld_o <= 1'b0;  reg_ld_o <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;  reg_we_o <= 1'b0;
      mem_rinc_o <= 1'b0; reg_rinc_o <= 1'b0;
      mem_ld_o <= 1'b0;  reg_ld_o <= 1'b0;
      if (start_i) begin
        state <= ST_RX; role <= RL_ADDR; cnt <= '0; drive_o <= 1'b0;
      end else if (stop_i) begin
        state <= ST_IDLE; drive_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: if (scl_rise_i) begin
            sh  <= rx_byte;
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin
              state <= ST_ACKSET;
              ack_q <= 1'b1;
              unique case (role)
                RL_ADDR: begin
                  ack_q  <= id_ok;
                  is_reg <= (rx_byte[7:4] == ID_REG);
                  is_rd  <= rx_byte[0];
                  if (rx_byte[0])                  role <= RL_DATA;
                  else if (rx_byte[7:4] == ID_REG) role <= RL_RADDR;
                  else                             role <= RL_AHI;
                end
                RL_AHI: begin hi_q <= rx_byte; role <= RL_ALO; end
                RL_ALO: begin
                  mem_ld_o <= 1'b1; ld_val_o <= {hi_q, rx_byte}; role <= RL_DATA;
                end
                RL_RADDR: begin
                  if (rx_byte <= REG_LAST) begin
                    reg_ld_o <= 1'b1; ld_val_o <= {8'h00, rx_byte}; role <= RL_DATA;
                  end else ack_q <= 1'b0;
                end
                default: begin
                  wdata_o <= rx_byte;
                  if (is_reg) reg_we_o <= 1'b1;
                  else        mem_we_o <= 1'b1;
                end
              endcase
            end
          end
          ST_ACKSET: if (scl_fall_i) begin
            if (ack_q) begin drive_o <= 1'b1; state <= ST_SACK; end
            else state <= ST_IDLE;
          end
          ST_SACK: if (scl_fall_i) begin
            cnt <= '0;
            if (is_rd && role == RL_DATA) begin
              sh <= rd_byte; drive_o <= ~rd_byte[7]; state <= ST_TX;
            end else begin
              drive_o <= 1'b0; state <= ST_RX;
            end
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt == 3'd7) begin
              drive_o <= 1'b0; state <= ST_MACK;
              if (is_reg) reg_rinc_o <= 1'b1;
              else        mem_rinc_o <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1; sh <= {sh[6:0], 1'b0}; drive_o <= ~sh[6];
            end
          end
          ST_MACK: if (scl_rise_i) state <= sda_i ? ST_IDLE : ST_MNEXT;
          ST_MNEXT: if (scl_fall_i) begin
            cnt <= '0; sh <= rd_byte; drive_o <= ~rd_byte[7]; state <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_i2c_slave.sv
module dual_i2c_slave
  import dual_i2c_pkg::*;
#(
  parameter int         MEM_AW      = 16,
  parameter logic [7:0] REG_LAST    = 8'h18,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_no,
  input  logic [1:0]        sel_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  output logic              reg_we_o,
  input  logic [7:0]        reg_rdata_i
);
  logic sda_s, scl_rise, scl_fall, start, stop, drive;
  logic [7:0] wdata;
  logic mem_we, reg_we, mem_rinc, reg_rinc, mem_ld, reg_ld;
  logic [LDW-1:0] ld_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_slave_ctrl #(.REG_LAST(REG_LAST)) u_ctrl (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .sel_i, .mem_rdata_i, .reg_rdata_i,
    .drive_o(drive), .wdata_o(wdata), .mem_we_o(mem_we), .reg_we_o(reg_we),
    .mem_rinc_o(mem_rinc), .reg_rinc_o(reg_rinc), .mem_ld_o(mem_ld),
    .reg_ld_o(reg_ld), .ld_val_o(ld_val)
  );

  i2c_addr_ptr #(.W(MEM_AW)) u_mem_ptr (
    .clk_i, .rst_ni, .ld_i(mem_ld), .ld_val_i(ld_val[MEM_AW-1:0]),
    .inc_i(mem_we | mem_rinc), .ptr_o(mem_addr_o)
  );

  i2c_addr_ptr #(.W(8), .LAST(REG_LAST)) u_reg_ptr (
    .clk_i, .rst_ni, .ld_i(reg_ld), .ld_val_i(ld_val[7:0]),
    .inc_i(reg_we | reg_rinc), .ptr_o(reg_addr_o)
  );

  assign sda_oe_no   = ~drive;
  assign mem_wdata_o = wdata;
  assign reg_wdata_o = wdata;
  assign mem_we_o    = mem_we;
  assign reg_we_o    = reg_we;
endmodule

// File: rtl/dual_i2c_slave_chk.sv
module dual_i2c_slave_chk #(
  parameter int         MEM_AW   = 16,
  parameter logic [7:0] REG_LAST = 8'h18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_no,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [7:0]        reg_addr_o,
  input logic              reg_we_o
);
  p_oe_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_no) |-> !scl_i);

  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && reg_we_o));

  p_mem_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  p_reg_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_mem_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> mem_addr_o == MEM_AW'($past(mem_addr_o) + 1'b1));

  p_reg_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_o <= REG_LAST);

  p_reg_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> reg_addr_o ==
      (($past(reg_addr_o) == REG_LAST) ? 8'h00 : $past(reg_addr_o) + 8'd1));

  p_mem_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $stable(mem_addr_o));
endmodule

bind dual_i2c_slave dual_i2c_slave_chk #(.MEM_AW(MEM_AW), .REG_LAST(REG_LAST)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_no(sda_oe_no),
  .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
  .reg_addr_o(reg_addr_o), .reg_we_o(reg_we_o)
);

// File: tb/dual_i2c_slave_test.sv
module dual_i2c_slave_test;
  localparam int AW = 8;
  localparam int Q  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] sel = 2'b10;
  logic sda_oe_n;
  logic sda_bus;
  assign sda_bus = sda_m & sda_oe_n;

  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, reg_addr, reg_wdata, reg_rdata;
  logic mem_we, reg_we;

  logic [7:0] mem [256];
  logic [7:0] regs [25];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_reg [25];
  int mem_we_cnt = 0, reg_we_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic oe_a, oe_b;

  assign mem_rdata = mem[mem_addr];
  assign reg_rdata = (reg_addr <= 8'd24) ? regs[reg_addr[4:0]] : 8'h00;

  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr] <= mem_wdata; mem_we_cnt <= mem_we_cnt + 1; end
    if (reg_we) begin
      if (reg_addr <= 8'd24) regs[reg_addr[4:0]] <= reg_wdata;
      reg_we_cnt <= reg_we_cnt + 1;
    end
  end

  dual_i2c_slave #(.MEM_AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_no(sda_oe_n),
    .sel_i(sel), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  task automatic wc(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wc(Q); scl = 1'b1; wc(Q); sda_m = 1'b0; wc(Q); scl = 1'b0;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wc(Q); scl = 1'b1; wc(Q); sda_m = 1'b1; wc(Q);
  endtask

  task automatic bit_out(input logic v);
    sda_m = v; wc(Q); scl = 1'b1; wc(Q); scl = 1'b0;
  endtask

  task automatic bit_in(output logic v);
    sda_m = 1'b1; wc(Q); scl = 1'b1; wc(Q/2); v = sda_bus; wc(Q/2); scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; wc(Q); scl = 1'b1; wc(1); oe_a = sda_oe_n;
    wc(Q/2 - 1); ack = ~sda_bus; wc(Q/2 - 1); oe_b = sda_oe_n; wc(1); scl = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic mack);
    logic v;
    for (int i = 7; i >= 0; i--) begin bit_in(v); b[i] = v; end
    bit_out(~mack);
  endtask

  function automatic logic [7:0] maddr(input logic rw);
    return {4'hA, 1'b0, sel, rw};
  endfunction
  function automatic logic [7:0] raddr(input logic rw);
    return {4'hD, 1'b0, sel, rw};
  endfunction

  initial begin
    logic ack;
    logic [7:0] d;
    int wb, rb;
    logic [7:0] mp;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
    for (int i = 0; i < 25; i++) begin regs[i] = 8'(i) ^ 8'h5A; exp_reg[i] = 8'(i) ^ 8'h5A; end

    wc(5);
    chk(sda_oe_n == 1'b1, "R9 reset oe", 32'(sda_oe_n), 1);
    chk(!mem_we && !reg_we, "R10 reset strobes", {30'd0, mem_we, reg_we}, 0);
    rst_n = 1'b1; wc(5);

    // R1: every first-byte value
    for (int a = 0; a < 256; a++) begin
      logic [7:0] ab;
      bit exp_ack;
      ab = 8'(a);
      exp_ack = (ab[7:4] == 4'hA || ab[7:4] == 4'hD) && ab[2:1] == sel;
      i2c_start; wr_byte(ab, ack);
      chk(ack == exp_ack, "R1 decode", {24'd0, ab}, 32'(exp_ack));
      if (ack && ab[0]) rd_byte(d, 1'b0);
      i2c_stop;
    end

    // R1: strap sweep
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 4; f++) begin
        sel = 2'(s);
        i2c_start; wr_byte({4'hA, 1'b1, 2'(f), 1'b0}, ack); i2c_stop;
        chk(ack == (f == s), "R1 strap", 32'(ack), 32'(f == s));
      end
    sel = 2'b10;

    // R3, R2, R10, R7: memory write wrapping past the top
    wb = mem_we_cnt; rb = reg_we_cnt;
    i2c_start;
    wr_byte(maddr(1'b0), ack); chk(ack, "R2 addr ack", 32'(ack), 1);
    chk(oe_a == 1'b0 && oe_b == 1'b0, "R9 ack held over SCL high", {30'd0, oe_a, oe_b}, 0);
    wr_byte(8'h37, ack); chk(ack, "R3 hi ack", 32'(ack), 1);
    wr_byte(8'hFE, ack); chk(ack, "R3 lo ack", 32'(ack), 1);
    begin
      logic [7:0] dv [4];
      dv = '{8'hA5, 8'h3C, 8'h0F, 8'hC3};
      for (int i = 0; i < 4; i++) begin
        wr_byte(dv[i], ack); chk(ack, "R2 data ack", 32'(ack), 1);
        exp_mem[8'(8'hFE + i)] = dv[i];
      end
    end
    i2c_stop; wc(4);
    chk(mem_addr == 8'h02, "R3 pointer wrap", 32'(mem_addr), 32'h02);
    chk(mem_we_cnt - wb == 4, "R10 one strobe per byte", 32'(mem_we_cnt - wb), 4);
    chk(reg_we_cnt == rb, "R7 memory write leaves registers", 32'(reg_we_cnt), 32'(rb));

    // R4: random read across the wrap
    i2c_start; wr_byte(maddr(1'b0), ack); wr_byte(8'h00, ack); wr_byte(8'hFD, ack);
    i2c_start; wr_byte(maddr(1'b1), ack); chk(ack, "R4 read addr ack", 32'(ack), 1);
    for (int i = 0; i < 5; i++) begin
      rd_byte(d, i < 4);
      chk(d == exp_mem[8'(8'hFD + i)], "R4 read data", 32'(d), 32'(exp_mem[8'(8'hFD + i)]));
    end
    wc(Q);
    chk(sda_oe_n == 1'b1, "R4 released after NACK", 32'(sda_oe_n), 1);
    i2c_stop; wc(4);
    chk(mem_addr == 8'h02, "R4 pointer after read", 32'(mem_addr), 32'h02);

    // R6, R7: register write wrapping at the last register
    mp = mem_addr; wb = mem_we_cnt; rb = reg_we_cnt;
    i2c_start; wr_byte(raddr(1'b0), ack); chk(ack, "R1 reg addr ack", 32'(ack), 1);
    wr_byte(8'h16, ack); chk(ack, "R5 reg index ack", 32'(ack), 1);
    for (int i = 0; i < 4; i++) begin
      int ix;
      ix = (8'h16 + i) % 25;
      wr_byte(8'(8'h11 * (i + 1)), ack); exp_reg[ix] = 8'(8'h11 * (i + 1));
    end
    i2c_stop; wc(4);
    chk(reg_addr == 8'h01, "R6 reg pointer wrap", 32'(reg_addr), 1);
    chk(reg_we_cnt - rb == 4, "R10 reg strobes", 32'(reg_we_cnt - rb), 4);
    chk(mem_we_cnt == wb, "R7 no memory write", 32'(mem_we_cnt), 32'(wb));
    chk(mem_addr == mp, "R7 memory pointer held", 32'(mem_addr), 32'(mp));

    i2c_start; wr_byte(raddr(1'b0), ack); wr_byte(8'h15, ack);
    i2c_start; wr_byte(raddr(1'b1), ack);
    for (int i = 0; i < 5; i++) begin
      int ix;
      ix = (8'h15 + i) % 25;
      rd_byte(d, i < 4);
      chk(d == exp_reg[ix], "R6 reg read", 32'(d), 32'(exp_reg[ix]));
    end
    i2c_stop; wc(4);
    chk(reg_addr == 8'h01, "R6 pointer after read", 32'(reg_addr), 1);
    chk(mem_addr == mp, "R7 memory pointer held on reg read", 32'(mem_addr), 32'(mp));

    // R5: range boundary and abort
    i2c_start; wr_byte(raddr(1'b0), ack); wr_byte(8'h19, ack); i2c_stop;
    chk(!ack, "R5 19h nack", 32'(ack), 0);
    wc(4); chk(reg_addr == 8'h01, "R5 pointer kept", 32'(reg_addr), 1);
    rb = reg_we_cnt;
    i2c_start; wr_byte(raddr(1'b0), ack); wr_byte(8'hFF, ack);
    chk(!ack, "R5 FFh nack", 32'(ack), 0);
    wr_byte(8'h55, ack); chk(!ack, "R5 abort ignores data", 32'(ack), 0);
    i2c_stop; wc(4);
    chk(reg_we_cnt == rb, "R5 no write after abort", 32'(reg_we_cnt), 32'(rb));
    i2c_start; wr_byte(raddr(1'b0), ack); wr_byte(8'h18, ack); i2c_stop;
    chk(ack, "R5 18h accepted", 32'(ack), 1);

    // R8: repeated START partway through a data byte
    wb = mem_we_cnt;
    i2c_start; wr_byte(maddr(1'b0), ack); wr_byte(8'h00, ack); wr_byte(8'h10, ack);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    i2c_start; wr_byte(raddr(1'b1), ack); chk(ack, "R8 restart address ack", 32'(ack), 1);
    rd_byte(d, 1'b0);
    chk(d == exp_reg[24], "R8 read after restart", 32'(d), 32'(exp_reg[24]));
    i2c_stop; wc(4);
    chk(mem_we_cnt == wb, "R8 partial byte dropped", 32'(mem_we_cnt), 32'(wb));
    chk(reg_addr == 8'h00, "R6 read wrap at last", 32'(reg_addr), 0);

    // R8: no START after STOP
    wr_byte(maddr(1'b0), ack);
    chk(!ack, "R8 ignored without START", 32'(ack), 0);
    wc(Q);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule